// File: doc/BRIEF.md
# Four-Level Page Table Walker

The block turns a 64-bit virtual address into a 40-bit physical address. It walks a tree of four tables held in memory. Each table has 512 entries of 8 bytes. The walk starts at a table whose frame number comes from a root input, which is sampled when a request is accepted. Each level takes nine bits of the virtual address as its index. Each entry it reads gives the frame of the next table, or at the last level the frame of the page. The 12-bit page offset is passed through unchanged.

The walker handles one translation at a time. The sequence for one request is:

1. A request is accepted on a valid/ready handshake.
2. The address is checked for the canonical form. An address that fails gets a fault at once, with no memory read.
3. The walker issues one 64-bit read per level and waits for each response before going on.

Every request produces exactly one response pulse. The pulse carries the physical address, a fault code and the level the walk reached. A request marked as an instruction fetch also faults if any entry on its path has the top-bit execute-disable flag set.

Top module: `pt_walker`

## Requirements
- R1: After reset `reqReady` is 1, while `rspValid` and `memReqValid` are 0. `reqReady` is 1 only while the walker is idle, and then neither `rspValid` nor `memReqValid` is high.
- R2: An address whose bits 63:48 are not all equal to bit 47 returns fault code 1 with `rspLevel` 0, and no memory read is made for it.
- R3: For level L (0 = first table, 3 = last table), the read address is the table frame shifted left by 12, plus 8 times the index. The index of level L is virtual address bits [47-9L : 39-9L]. The level-0 table frame is `rootFrame`. Each later table frame is bits 39:12 of the entry read at the level before.
- R4: A successful translation makes exactly four memory reads, one per level, in order from level 0 to level 3.
- R5: A successful translation returns fault code 0 and `rspLevel` 3. `rspPaddr` is bits 39:12 of the level-3 entry joined to virtual address bits 11:0.
- R6: An entry with bit 0 (present) clear ends the walk with fault code 2. `rspLevel` gives the level of that entry, and no further read is made.
- R7: When `reqExec` is 1, an entry with bit 63 set at any level ends the walk with fault code 3 and that level. When `reqExec` is 0, bit 63 has no effect on the result.
- R8: The present bit is tested before the execute-disable bit, so an entry with bit 0 clear and bit 63 set returns fault code 2 even for a fetch.
- R9: `rspValid` is a single-cycle pulse. While a walk is in progress, `reqReady` is 0 and a held `reqValid` is not accepted.
- R10: `memReqValid` is a single-cycle strobe, and no new read is issued until the response to the previous one has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootFrame | input | 28 | Frame number of the level-0 table, sampled on acceptance |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle and able to accept |
| reqVaddr | input | 64 | Virtual address to translate |
| reqExec | input | 1 | Request is an instruction fetch |
| memReqValid | output | 1 | Single-cycle table read strobe |
| memReqAddr | output | 40 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Entry read from memory |
| rspValid | output | 1 | Result pulse |
| rspPaddr | output | 40 | Physical address (zero on a fault) |
| rspFault | output | 2 | 0 ok, 1 non-canonical, 2 not present, 3 execute-disabled |
| rspLevel | output | 2 | Level the walk ended at |

## Verification
The bench tries the walker with the following inputs:

- **Lower-half and upper-half canonical addresses.** These separate the sign-extension check from the index slicing.
- **Three kinds of non-canonical address** (high bits partly set, bit 47 set with a clear upper bit, bit 47 clear with set upper bits). These show that the check compares against bit 47 rather than testing for zero.
- **Missing entries at the first and third levels.** These show that the fault reports the right level and that the walk stops early.
- **Execute-disable marks at a middle level and at the last level, each tried as a fetch and as a data access.** These show that the flag matters only for fetches.
- **One entry that is both absent and marked execute-disabled.** This fixes which of the two tests comes first.

Memory latency is varied between reads so that the response wait is exercised.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    FLT_NONE      = 2'd0,
    FLT_NONCANON  = 2'd1,
    FLT_ABSENT    = 2'd2,
    FLT_NOEXEC    = 2'd3
  } fault_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   capture;   // latch request, reset level, load root frame
    logic   advance;   // take next table frame from entry, step level
    logic   finish;    // form final physical address
    logic   setFault;  // record faultCode at current level
    fault_e faultCode;
  } ptw_ctl_t;

endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int PA_W   = 40,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int ENT_W  = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ptw_ctl_t                ctl,
  input  logic [VA_W-1:0]         reqVaddr,
  input  logic                    reqExec,
  input  logic [PA_W-OFF_W-1:0]   rootFrame,
  input  logic [ENT_W-1:0]        memRspData,
  output logic [PA_W-1:0]         memReqAddr,
  output logic                    isCanonical,
  output logic                    entryPresent,
  output logic                    entryNoExec,
  output logic                    atLast,
  output logic [PA_W-1:0]         rspPaddr,
  output fault_e                  rspFault,
  output logic [$clog2(LEVELS)-1:0] rspLevel
);
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int LVL_W   = $clog2(LEVELS);
  localparam int VA_TOP  = OFF_W + LEVELS * IDX_W;   // first sign-extension bit
  localparam int ENT_SH  = $clog2(ENT_W / 8);
  localparam int PAD_W   = PA_W - IDX_W - ENT_SH;

  logic [VA_W-1:0]    vaReg;
  logic               execReg;
  logic [FRAME_W-1:0] baseReg;
  logic [LVL_W-1:0]   lvlReg;
  logic [PA_W-1:0]    paddrReg;
  fault_e             faultReg;
  logic [LVL_W-1:0]   levelReg;

  logic [IDX_W-1:0]   idxArr [LEVELS];
  logic [IDX_W-1:0]   curIdx;
  logic [FRAME_W-1:0] nextFrame;
  logic [VA_W-VA_TOP:0] signBits;

  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idxArr[l] = vaReg[OFF_W + (LEVELS-1-l)*IDX_W +: IDX_W];
  end

  assign curIdx       = idxArr[lvlReg];
  assign memReqAddr   = {baseReg, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, curIdx, {ENT_SH{1'b0}}};
  assign signBits     = vaReg[VA_W-1:VA_TOP-1];
  assign isCanonical  = (&signBits) | ~(|signBits);
  assign nextFrame    = memRspData[PA_W-1:OFF_W];
  assign entryPresent = memRspData[0];
  assign entryNoExec  = execReg & memRspData[ENT_W-1];
  assign atLast       = (lvlReg == LVL_W'(LEVELS-1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg    <= '0;
      execReg  <= 1'b0;
      baseReg  <= '0;
      lvlReg   <= '0;
      paddrReg <= '0;
      faultReg <= FLT_NONE;
      levelReg <= '0;
    end else begin
      if (ctl.capture) begin
        vaReg   <= reqVaddr;
        execReg <= reqExec;
        baseReg <= rootFrame;
        lvlReg  <= '0;
      end
      if (ctl.advance) begin
        baseReg <= nextFrame;
        lvlReg  <= lvlReg + 1'b1;
      end
      if (ctl.finish) begin
        paddrReg <= {nextFrame, vaReg[OFF_W-1:0]};
        faultReg <= FLT_NONE;
        levelReg <= lvlReg;
      end
      if (ctl.setFault) begin
        paddrReg <= '0;
        faultReg <= ctl.faultCode;
        levelReg <= lvlReg;
      end
    end
  end

  assign rspPaddr = paddrReg;
  assign rspFault = faultReg;
  assign rspLevel = levelReg;

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     memRspValid,
  input  logic     isCanonical,
  input  logic     entryPresent,
  input  logic     entryNoExec,
  input  logic     atLast,
  output logic     reqReady,
  output logic     memReqValid,
  output logic     rspValid,
  output ptw_ctl_t ctl
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_ISSUE, ST_WAIT, ST_DONE
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext     = state;
    ctl           = '0;
    ctl.faultCode = FLT_NONE;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctl.capture = 1'b1;
        stateNext   = ST_CHECK;
      end
      ST_CHECK: if (!isCanonical) begin
        ctl.setFault  = 1'b1;
        ctl.faultCode = FLT_NONCANON;
        stateNext     = ST_DONE;
      end else begin
        stateNext = ST_ISSUE;
      end
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT: if (memRspValid) begin
        if (!entryPresent) begin
          ctl.setFault  = 1'b1;
          ctl.faultCode = FLT_ABSENT;
          stateNext     = ST_DONE;
        end else if (entryNoExec) begin
          ctl.setFault  = 1'b1;
          ctl.faultCode = FLT_NOEXEC;
          stateNext     = ST_DONE;
        end else if (atLast) begin
          ctl.finish = 1'b1;
          stateNext  = ST_DONE;
        end else begin
          ctl.advance = 1'b1;
          stateNext   = ST_ISSUE;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_ISSUE);
  assign rspValid    = (state == ST_DONE);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int PA_W   = 40,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int ENT_W  = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [PA_W-OFF_W-1:0]     rootFrame,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [VA_W-1:0]           reqVaddr,
  input  logic                      reqExec,
  output logic                      memReqValid,
  output logic [PA_W-1:0]           memReqAddr,
  input  logic                      memRspValid,
  input  logic [ENT_W-1:0]          memRspData,
  output logic                      rspValid,
  output logic [PA_W-1:0]           rspPaddr,
  output logic [1:0]                rspFault,
  output logic [$clog2(LEVELS)-1:0] rspLevel
);
  ptw_ctl_t ctl;
  logic     isCanonical, entryPresent, entryNoExec, atLast;
  fault_e   faultSig;

  ptw_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .memRspValid  (memRspValid),
    .isCanonical  (isCanonical),
    .entryPresent (entryPresent),
    .entryNoExec  (entryNoExec),
    .atLast       (atLast),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .rspValid     (rspValid),
    .ctl          (ctl)
  );

  ptw_datapath #(
    .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS),
    .IDX_W(IDX_W), .OFF_W(OFF_W), .ENT_W(ENT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .reqVaddr     (reqVaddr),
    .reqExec      (reqExec),
    .rootFrame    (rootFrame),
    .memRspData   (memRspData),
    .memReqAddr   (memReqAddr),
    .isCanonical  (isCanonical),
    .entryPresent (entryPresent),
    .entryNoExec  (entryNoExec),
    .atLast       (atLast),
    .rspPaddr     (rspPaddr),
    .rspFault     (faultSig),
    .rspLevel     (rspLevel)
  );

  assign rspFault = faultSig;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W   = 64,
  parameter int PA_W   = 40,
  parameter int LEVELS = 4,
  parameter int OFF_W  = 12
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      reqValid,
  input logic                      reqReady,
  input logic [VA_W-1:0]           reqVaddr,
  input logic                      memReqValid,
  input logic                      rspValid,
  input logic [PA_W-1:0]           rspPaddr,
  input logic [1:0]                rspFault,
  input logic [$clog2(LEVELS)-1:0] rspLevel
);
  localparam int CNT_W = $clog2(LEVELS + 1) + 1;

  logic [CNT_W-1:0] readCnt;   // reads since the last accepted request
  logic [OFF_W-1:0] offLatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readCnt  <= '0;
      offLatch <= '0;
    end else if (reqValid && reqReady) begin
      readCnt  <= '0;
      offLatch <= reqVaddr[OFF_W-1:0];
    end else if (memReqValid) begin
      readCnt  <= readCnt + 1'b1;
    end
  end

  assert_ready_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memReqValid && !rspValid));

  assert_noncanon_nomem_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'd1) |-> (readCnt == '0 && rspLevel == '0));

  assert_four_reads_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'd0) |-> (readCnt == CNT_W'(LEVELS)));

  assert_offset_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'd0) |-> (rspPaddr[OFF_W-1:0] == offLatch));

  assert_absent_stops_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'd2) |-> (int'(readCnt) == int'(rspLevel) + 1));

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_read_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

endmodule

bind pt_walker pt_walker_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS), .OFF_W(OFF_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqVaddr    (reqVaddr),
  .memReqValid (memReqValid),
  .rspValid    (rspValid),
  .rspPaddr    (rspPaddr),
  .rspFault    (rspFault),
  .rspLevel    (rspLevel)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;

  localparam logic [27:0] ROOT = 28'h0000100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqVaddr = '0;
  logic        reqExec = 1'b0;
  logic        memReqValid;
  logic [39:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        rspValid;
  logic [39:0] rspPaddr;
  logic [1:0]  rspFault;
  logic [1:0]  rspLevel;

  always #2.5 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rstN(rstN), .rootFrame(ROOT),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqExec(reqExec),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspFault(rspFault), .rspLevel(rspLevel)
  );

  typedef struct {
    logic [39:0] pa;
    logic [1:0]  flt;
    logic [1:0]  lvl;
    int          nreads;
    int          startReads;
    string       tag;
  } exp_t;

  int          nChk = 0;
  int          nBad = 0;
  int          totalReads = 0;
  exp_t        expQ[$];
  logic [39:0] addrQ[$];
  logic [63:0] mem [logic [39:0]];

  task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [39:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [8:0] idxOf(input logic [63:0] va, input int l);
    return va[47 - 9*l -: 9];
  endfunction

  task automatic link(input logic [27:0] tbl, input logic [8:0] ix, input logic [27:0] nxt, input logic nx);
    mem[{tbl, 12'h000} + {28'd0, ix, 3'b000}] = {nx, 23'd0, nxt, 11'd0, 1'b1};
  endtask

  task automatic mapVa(input logic [63:0] va, input logic [27:0] f1, input logic [27:0] f2,
                       input logic [27:0] f3, input logic [27:0] pg, input logic [3:0] nx);
    link(ROOT, idxOf(va, 0), f1, nx[0]);
    link(f1,   idxOf(va, 1), f2, nx[1]);
    link(f2,   idxOf(va, 2), f3, nx[2]);
    link(f3,   idxOf(va, 3), pg, nx[3]);
  endtask

  // reference walk, computed from the requirements
  function automatic exp_t model(input logic [63:0] va, input logic ex);
    exp_t e;
    logic [27:0] base;
    logic [63:0] ent;
    logic [39:0] a;
    e.pa = '0; e.flt = 2'd0; e.lvl = 2'd0; e.nreads = 0; e.startReads = 0; e.tag = "";
    if (!((&va[63:47]) || !(|va[63:47]))) begin
      e.flt = 2'd1;
      return e;
    end
    base = ROOT;
    for (int l = 0; l < 4; l++) begin
      a = {base, 12'h000} + {28'd0, idxOf(va, l), 3'b000};
      addrQ.push_back(a);
      e.nreads++;
      ent = rd(a);
      e.lvl = 2'(l);
      if (!ent[0]) begin e.flt = 2'd2; return e; end
      if (ex && ent[63]) begin e.flt = 2'd3; return e; end
      base = ent[39:12];
    end
    e.pa = {base, va[11:0]};
    return e;
  endfunction

  // behavioural table memory with varying latency
  logic        pend = 1'b0;
  int          cnt = 0;
  int          latSel = 0;
  logic [39:0] pendAddr = '0;
  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        memRspValid = 1'b1;
        memRspData  = rd(pendAddr);
        pend        = 1'b0;
      end else cnt--;
    end
    if (rstN && memReqValid) begin
      cmp("R10", "read issued while one outstanding", 64'(pend), 64'd0);
      if (addrQ.size() == 0) cmp("R3", "unexpected read address", 64'(memReqAddr), 64'd0);
      else cmp("R3", "read address", 64'(memReqAddr), 64'(addrQ.pop_front()));
      totalReads++;
      pend     = 1'b1;
      pendAddr = memReqAddr;
      cnt      = (latSel % 4 == 0) ? 0 : (latSel % 4 == 1) ? 2 : (latSel % 4 == 2) ? 1 : 4;
      latSel++;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        cmp("R9", "response with nothing pending", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        cmp(e.tag, "fault code", 64'(rspFault), 64'(e.flt));
        cmp(e.tag, "level", 64'(rspLevel), 64'(e.lvl));
        cmp(e.tag, "physical address", 64'(rspPaddr), 64'(e.pa));
        cmp("R4", "read count", 64'(totalReads - e.startReads), 64'(e.nreads));
      end
    end
  end

  // driver: push expectation, issue, hold reqValid into the busy window
  task automatic run(input logic [63:0] va, input logic ex, input string tag);
    exp_t e;
    while (!reqReady) @(negedge clk);
    e = model(va, ex);
    e.startReads = totalReads;
    e.tag = tag;
    expQ.push_back(e);
    reqValid = 1'b1; reqVaddr = va; reqExec = ex;
    @(negedge clk);
    cmp("R9", "ready while busy", 64'(reqReady), 64'd0);
    reqVaddr = 64'h0001_0000_0000_0000;   // would be a second request if accepted
    @(negedge clk);
    cmp("R9", "ready while busy", 64'(reqReady), 64'd0);
    reqValid = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  localparam logic [63:0] VA_LO   = 64'h0000_1234_5678_9ABC;
  localparam logic [63:0] VA_HI   = 64'hFFFF_8000_0040_2123;
  localparam logic [63:0] VA_NP2  = 64'h0000_0080_0000_0000;
  localparam logic [63:0] VA_NP0  = 64'h0000_7F80_0000_0000;
  localparam logic [63:0] VA_NXM  = 64'h0000_0100_0000_5A5A;
  localparam logic [63:0] VA_BOTH = 64'h0000_0180_0000_0000;
  localparam logic [63:0] VA_NXL  = 64'h0000_0200_0000_7777;

  initial begin
    mapVa(VA_LO,  28'h200, 28'h201, 28'h202, 28'h0ABCDE, 4'b0000);
    mapVa(VA_HI,  28'h210, 28'h211, 28'h212, 28'h0FFFFF, 4'b0000);
    link(ROOT, idxOf(VA_NP2, 0), 28'h220, 1'b0);
    link(28'h220, idxOf(VA_NP2, 1), 28'h221, 1'b0);
    mapVa(VA_NXM, 28'h230, 28'h231, 28'h232, 28'h003333, 4'b0010);
    mem[{ROOT, 12'h000} + {28'd0, idxOf(VA_BOTH, 0), 3'b000}] = {1'b1, 23'd0, 28'h240, 12'h000};
    mapVa(VA_NXL, 28'h250, 28'h251, 28'h252, 28'h004444, 4'b1000);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    cmp("R1", "ready after reset", 64'(reqReady), 64'd1);
    cmp("R1", "rspValid after reset", 64'(rspValid), 64'd0);
    cmp("R1", "memReqValid after reset", 64'(memReqValid), 64'd0);

    run(VA_LO, 1'b0, "R5");                          // lower half success
    run(VA_HI, 1'b1, "R5");                          // upper half success, fetch
    run(64'h0001_0000_0000_0000, 1'b0, "R2");        // stray high bit
    run(64'h7FFF_8000_0000_0000, 1'b0, "R2");        // bit47 set, bit63 clear
    run(64'hFFFF_0000_0000_0000, 1'b1, "R2");        // bit47 clear, upper set
    run(VA_NP2, 1'b0, "R6");                         // absent at level 2
    run(VA_NP0, 1'b0, "R6");                         // absent at level 0
    run(VA_NXM, 1'b1, "R7");                         // fetch, NX at level 1
    run(VA_NXM, 1'b0, "R7");                         // data, NX ignored
    run(VA_BOTH, 1'b1, "R8");                        // absent and NX together
    run(VA_NXL, 1'b1, "R7");                         // fetch, NX at level 3
    run(VA_NXL, 1'b0, "R7");                         // data, NX ignored
    run(VA_LO, 1'b1, "R5");                          // repeat as fetch

    cmp("R3", "unused expected reads", 64'(addrQ.size()), 64'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule